// File: doc/BRIEF.md
# Parallel ROM Read Controller

This block connects a synchronous host to an array of asynchronous byte-wide ROM devices. All devices share one address bus, one 8-bit data bus and one active-low output-enable strobe. Each device also has its own active-low chip-enable line. The host presents a 16-bit address and a device (bank) number with a valid/ready handshake. The controller then drops the chip enable of exactly one device, delays the shared output enable, waits until the device's access times have passed, samples the data bus and returns the byte with a one-cycle valid pulse. Devices that are not selected stay in their low-power standby state with their outputs floating.

All device timings are given as parameters in picoseconds, together with the clock period. They are turned into cycle counts by rounding up:
- `ACC_CYC` is the larger of the address-to-data and chip-enable-to-data times.
- `OE_CYC` is the output-enable-to-data time.
- `FLT_CYC` is the time the outputs keep driving after a strobe rises.
- The output-enable delay `OE_DLY` is `ACC_CYC - OE_CYC`, or 0 when that is negative.

With the defaults (8 ns clock, 45/45/25/25 ns) these give `ACC_CYC` = 6, `OE_DLY` = 2 and `FLT_CYC` = 4.

The controller also keeps two devices from driving the bus at once. When an access goes to a different device than the one just read, it waits until the previous device's float time has expired.

Top module: `prom_rd_ctrl`

## Requirements
- R1: During and directly after reset, every chip-enable line and the output enable are high (inactive), `rsp_valid` is low and `req_ready` is high.
- R2: At most one chip-enable line is low in any cycle. The low line is bit `req_bank` of `rom_ce_n` for the accepted request. No line is low while no access is in progress.
- R3: `rom_oe_n` is low only while a chip enable is low. It falls exactly `OE_DLY` cycles after the chip enable falls (2 with defaults) and stays low until the sample edge.
- R4: A chip enable stays low for `ACC_CYC`+1 cycles (7 with defaults). The data bus is captured on the clock edge that ends that window. In the next cycle `rsp_valid` is high for exactly one cycle with the captured byte on `rsp_data`, and all strobes are already high.
- R5: `rom_addr` equals the address of the accepted request and is stable for the whole time the chip enable is low.
- R6: `req_ready` is high only while the controller is idle. It is low from the acceptance edge until the access ends. A request presented while `req_ready` is low has no effect: it produces no access and no response.
- R7: When the next access targets a different device, its chip enable does not fall until all chip enables have been high for at least `FLT_CYC` cycles (4 with defaults). A request that arrives earlier is held and starts exactly when that gap is reached.
- R8: When the next access targets the same device as the previous one, it starts on its acceptance edge. A request held waiting through the response cycle therefore leaves a single cycle with all chip enables high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_addr | input | ADDR_W | Byte address to read |
| req_bank | input | BANK_W | Device number to read from |
| rsp_valid | output | 1 | One-cycle pulse: `rsp_data` holds the read byte |
| rsp_data | output | DATA_W | Byte captured from the ROM bus |
| rom_addr | output | ADDR_W | Shared ROM address bus |
| rom_ce_n | output | NUM_DEV | Per-device active-low chip enables |
| rom_oe_n | output | 1 | Shared active-low output enable |
| rom_data | input | DATA_W | Shared ROM data bus |

## Verification
The bound checker watches the following on every cycle:
- that at most one device is selected;
- that the output enable appears only inside a chip-enable window and no earlier than its delay;
- that the response appears exactly one cycle after a window of the full access length;
- that the address holds while a device is selected;
- that the handshake stays closed during an access;
- that every change of device is preceded by at least the float gap.

Some properties only the bench scenarios can show. These are that the byte returned is the one the device drove at its valid time, that an early request to another device is started exactly at the end of the gap rather than later, that a same-device request is started with no gap, and that a request made while busy is lost without a trace. The bench's ROM model drives real data only after both access delays have elapsed, so a sample taken too early returns a wrong byte.

// File: rtl/prom_rd_pkg.sv
`timescale 1ns/1ps
package prom_rd_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_HOLD   = 2'd1,
      PH_ACCESS = 2'd2
   } rd_phase_e;

   // Round a time up to whole clock cycles.
   function automatic int cyc_ceil(input int t_ps, input int clk_ps);
      return (t_ps + clk_ps - 1) / clk_ps;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/prom_rd_bank_dec.sv
`timescale 1ns/1ps
// Decodes a device number into active-low per-device select lines.
module prom_rd_bank_dec #(
   parameter int NUM_DEV = 4,
   parameter int BANK_W  = 2
) (
   input  logic [BANK_W-1:0]  bank,
   output logic [NUM_DEV-1:0] sel_n
);
   for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
      assign sel_n[i] = (bank != BANK_W'(i));
   end
endmodule

// File: rtl/prom_rd_timer.sv
`timescale 1ns/1ps
// Counts cycles of one access and places the shared output-enable strobe.
module prom_rd_timer #(
   parameter int ACC_CYC = 6,
   parameter int OE_DLY  = 2,
   parameter int CNT_W   = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   output logic oe_n,
   output logic done
);
   logic [CNT_W-1:0] cnt_q;
   logic             oe_q;

   assign done = run && (cnt_q == CNT_W'(ACC_CYC));
   assign oe_n = oe_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start)          cnt_q <= '0;
      else if (run && !done)   cnt_q <= cnt_q + 1'b1;
   end

   if (OE_DLY == 0) begin : g_oe_with_ce
      always_ff @(posedge clk) begin
         if (!rst_n)      oe_q <= 1'b1;
         else if (start)  oe_q <= 1'b0;
         else if (done)   oe_q <= 1'b1;
      end
   end else begin : g_oe_delayed
      always_ff @(posedge clk) begin
         if (!rst_n)      oe_q <= 1'b1;
         else if (start)  oe_q <= 1'b1;
         else if (done)   oe_q <= 1'b1;
         else if (run && cnt_q == CNT_W'(OE_DLY - 1)) oe_q <= 1'b0;
      end
   end
endmodule

// File: rtl/prom_rd_float_guard.sv
`timescale 1ns/1ps
// Tracks the bus float time after an access and grants the next start.
module prom_rd_float_guard #(
   parameter int BANK_W  = 2,
   parameter int FLT_CYC = 4,
   parameter int FLT_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              finish,
   input  logic [BANK_W-1:0] fin_bank,
   input  logic [BANK_W-1:0] query_bank,
   output logic              go
);
   logic [FLT_W-1:0]  flt_q;
   logic [BANK_W-1:0] last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flt_q  <= '0;
         last_q <= '0;
      end else if (finish) begin
         flt_q  <= FLT_W'(FLT_CYC);
         last_q <= fin_bank;
      end else if (flt_q != '0) begin
         flt_q  <= flt_q - 1'b1;
      end
   end

   // A value of 1 or less means the gap ends at this edge.
   assign go = (flt_q <= FLT_W'(1)) || (query_bank == last_q);
endmodule

// File: rtl/prom_rd_ctrl.sv
`timescale 1ns/1ps
module prom_rd_ctrl import prom_rd_pkg::*; #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int NUM_DEV    = 4,
   parameter int CLK_PS     = 8000,
   parameter int T_ADDR_PS  = 45000,
   parameter int T_CE_PS    = 45000,
   parameter int T_OE_PS    = 25000,
   parameter int T_FLOAT_PS = 25000,
   localparam int BANK_W    = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [BANK_W-1:0]  req_bank,
   output logic               rsp_valid,
   output logic [DATA_W-1:0]  rsp_data,
   output logic [ADDR_W-1:0]  rom_addr,
   output logic [NUM_DEV-1:0] rom_ce_n,
   output logic               rom_oe_n,
   input  logic [DATA_W-1:0]  rom_data
);
   localparam int ACC_CYC = max2(cyc_ceil(T_ADDR_PS, CLK_PS), cyc_ceil(T_CE_PS, CLK_PS));
   localparam int OE_CYC  = cyc_ceil(T_OE_PS, CLK_PS);
   localparam int FLT_CYC = cyc_ceil(T_FLOAT_PS, CLK_PS);
   localparam int OE_DLY  = (ACC_CYC > OE_CYC) ? ACC_CYC - OE_CYC : 0;
   localparam int CNT_W   = $clog2(ACC_CYC + 1) + 1;
   localparam int FLT_W   = $clog2(FLT_CYC + 1) + 1;

   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("prom_rd_ctrl: bus widths must be positive");
   end
   if (NUM_DEV < 2) begin : g_bad_devs
      $error("prom_rd_ctrl: at least two devices are required");
   end
   if (CLK_PS <= 0 || T_ADDR_PS <= 0 || T_CE_PS <= 0 || T_OE_PS <= 0 || T_FLOAT_PS < 0) begin : g_bad_time
      $error("prom_rd_ctrl: timing parameters out of range");
   end

   rd_phase_e          phase_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [BANK_W-1:0]  bank_q;
   logic [BANK_W-1:0]  query_bank;
   logic [NUM_DEV-1:0] sel_n;
   logic [NUM_DEV-1:0] ce_n_q;
   logic [DATA_W-1:0]  data_q;
   logic               valid_q;
   logic               accept, go, start, finish, done;

   assign req_ready  = (phase_q == PH_IDLE);
   assign accept     = req_valid && req_ready;
   assign query_bank = (phase_q == PH_IDLE) ? req_bank : bank_q;
   assign start      = ((phase_q == PH_IDLE) && accept && go) ||
                       ((phase_q == PH_HOLD) && go);
   assign finish     = (phase_q == PH_ACCESS) && done;

   prom_rd_bank_dec #(.NUM_DEV(NUM_DEV), .BANK_W(BANK_W)) u_dec (
      .bank  (query_bank),
      .sel_n (sel_n)
   );

   prom_rd_timer #(.ACC_CYC(ACC_CYC), .OE_DLY(OE_DLY), .CNT_W(CNT_W)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .start (start),
      .run   (phase_q == PH_ACCESS),
      .oe_n  (rom_oe_n),
      .done  (done)
   );

   prom_rd_float_guard #(.BANK_W(BANK_W), .FLT_CYC(FLT_CYC), .FLT_W(FLT_W)) u_flt (
      .clk        (clk),
      .rst_n      (rst_n),
      .finish     (finish),
      .fin_bank   (bank_q),
      .query_bank (query_bank),
      .go         (go)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         addr_q  <= '0;
         bank_q  <= '0;
      end else begin
         case (phase_q)
            PH_IDLE: if (accept) begin
               addr_q  <= req_addr;
               bank_q  <= req_bank;
               phase_q <= go ? PH_ACCESS : PH_HOLD;
            end
            PH_HOLD:   if (go)   phase_q <= PH_ACCESS;
            PH_ACCESS: if (done) phase_q <= PH_IDLE;
            default:             phase_q <= PH_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       ce_n_q <= '1;
      else if (start)   ce_n_q <= sel_n;
      else if (finish)  ce_n_q <= '1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else begin
         valid_q <= finish;
         if (finish) data_q <= rom_data;
      end
   end

   assign rom_addr  = addr_q;
   assign rom_ce_n  = ce_n_q;
   assign rsp_valid = valid_q;
   assign rsp_data  = data_q;
endmodule

// File: rtl/prom_rd_ctrl_chk.sv
`timescale 1ns/1ps
module prom_rd_ctrl_chk #(
   parameter int ADDR_W  = 16,
   parameter int NUM_DEV = 4,
   parameter int ACC_CYC = 6,
   parameter int OE_DLY  = 2,
   parameter int FLT_CYC = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               rsp_valid,
   input logic [ADDR_W-1:0]  rom_addr,
   input logic [NUM_DEV-1:0] rom_ce_n,
   input logic               rom_oe_n
);
   logic               any_lo;
   logic [15:0]        lo_cnt, hi_cnt;
   logic [NUM_DEV-1:0] last_sel_n;

   assign any_lo = (rom_ce_n != {NUM_DEV{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_cnt     <= '0;
         hi_cnt     <= '1;
         last_sel_n <= '1;
      end else begin
         lo_cnt <= any_lo ? ((lo_cnt == '1) ? lo_cnt : lo_cnt + 1'b1) : '0;
         hi_cnt <= any_lo ? '0 : ((hi_cnt == '1) ? hi_cnt : hi_cnt + 1'b1);
         if (any_lo) last_sel_n <= rom_ce_n;
      end
   end

   p_one_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(~rom_ce_n) <= 1);

   p_oe_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !rom_oe_n |-> (any_lo && lo_cnt >= 16'(OE_DLY)));

   p_sample_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!any_lo && rom_oe_n && $past(any_lo) && $past(lo_cnt) == 16'(ACC_CYC)));

   p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (any_lo && $past(any_lo)) |-> $stable(rom_addr));

   p_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      any_lo |-> !req_ready);

   p_float_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (any_lo && !$past(any_lo) && rom_ce_n != last_sel_n) |-> hi_cnt >= 16'(FLT_CYC));
endmodule

bind prom_rd_ctrl prom_rd_ctrl_chk #(
   .ADDR_W  (ADDR_W),
   .NUM_DEV (NUM_DEV),
   .ACC_CYC (ACC_CYC),
   .OE_DLY  (OE_DLY),
   .FLT_CYC (FLT_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rom_addr  (rom_addr),
   .rom_ce_n  (rom_ce_n),
   .rom_oe_n  (rom_oe_n)
);

// File: tb/tb_prom_rd_ctrl.sv
`timescale 1ns/1ps
module tb_prom_rd_ctrl;
   localparam int CLKP = 8000;
   localparam int ACC  = (45000 + CLKP - 1) / CLKP;   // 6
   localparam int OEC  = (25000 + CLKP - 1) / CLKP;   // 4
   localparam int FLT  = (25000 + CLKP - 1) / CLKP;   // 4
   localparam int OED  = ACC - OEC;                   // 2

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_addr = '0;
   logic [1:0]  req_bank = '0;
   logic        rsp_valid;
   logic [7:0]  rsp_data;
   logic [15:0] rom_addr;
   logic [3:0]  rom_ce_n;
   logic        rom_oe_n;
   logic [7:0]  rom_data = 8'h5A;

   int n_chk = 0, n_fail = 0, cyc = 0;
   int lo_run = 0, hi_run = 1000, oe_run = 0;
   int last_lo = 0, last_gap = 0, last_oe = 0;
   int rsp_cnt = 0;
   logic [7:0] last_rsp = '0;

   // reference model state
   int m_phase = 0, m_cnt = 0, m_flt = 0, m_last = 0, m_bank = 0;
   logic [15:0] m_addr = '0;
   logic        m_valid = 1'b0;
   logic [7:0]  m_data = '0;

   always #4 clk = ~clk;

   prom_rd_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_bank(req_bank), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rom_addr(rom_addr), .rom_ce_n(rom_ce_n),
      .rom_oe_n(rom_oe_n), .rom_data(rom_data)
   );

   function automatic logic [7:0] rom_byte(input logic [15:0] a, input int b);
      return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'(b * 53 + 7);
   endfunction

   task automatic chk(input string tag, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // Reference model: advances once per rising edge from the inputs.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_cnt = 0; m_flt = 0; m_last = 0; m_valid = 1'b0;
      end else begin
         bit fin;
         bit gap_ok;
         fin = 1'b0;
         gap_ok = (m_flt <= 1);
         m_valid = 1'b0;
         case (m_phase)
            2: if (m_cnt == ACC) begin
                  m_valid = 1'b1; m_data = rom_byte(m_addr, m_bank);
                  m_phase = 0; m_last = m_bank; fin = 1'b1;
               end else m_cnt++;
            1: if (gap_ok) begin m_phase = 2; m_cnt = 0; end
            default: if (req_valid) begin
                  m_addr = req_addr; m_bank = int'(req_bank);
                  if (gap_ok || m_bank == m_last) begin m_phase = 2; m_cnt = 0; end
                  else m_phase = 1;
               end
         endcase
         if (fin) m_flt = FLT;
         else if (m_flt > 0) m_flt--;
      end
   end

   // Bus monitor, ROM model and per-cycle comparison, away from the active edge.
   always @(negedge clk) begin
      if (!rst_n) begin
         lo_run = 0; hi_run = 1000; oe_run = 0;
      end else begin
         int dev;
         logic [3:0] e_ce;
         if (rom_ce_n == 4'hF) begin
            if (lo_run > 0) begin last_lo = lo_run; lo_run = 0; end
            hi_run++;
         end else begin
            if (hi_run > 0) begin last_gap = hi_run; hi_run = 0; end
            lo_run++;
         end
         if (!rom_oe_n) oe_run++;
         else if (oe_run > 0) begin last_oe = oe_run; oe_run = 0; end
         dev = -1;
         for (int i = 0; i < 4; i++) if (!rom_ce_n[i]) dev = i;
         if (dev >= 0 && !rom_oe_n && lo_run >= ACC + 1 && oe_run >= OEC + 1)
            rom_data = rom_byte(rom_addr, dev);
         else
            rom_data = 8'h5A;
         if (rsp_valid) begin rsp_cnt++; last_rsp = rsp_data; end

         e_ce = (m_phase == 2) ? ~(4'b0001 << m_bank) : 4'hF;
         chk("R2", "chip enables", rom_ce_n, e_ce);
         chk("R3", "output enable", rom_oe_n, (m_phase == 2 && m_cnt >= OED) ? 0 : 1);
         chk("R6", "ready", req_ready, m_phase == 0);
         chk("R4", "response valid", rsp_valid, m_valid);
         if (m_valid) chk("R4", "response data", rsp_data, m_data);
         if (m_phase == 2) chk("R5", "address bus", rom_addr, m_addr);
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_chk++; n_fail++;
         $display("FAIL R6 watchdog: cycles=%0d expected below %0d", cyc, 20000);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   task automatic issue(input logic [15:0] a, input int b);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_bank = 2'(b);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_rsp(input int target);
      #1;
      while (rsp_cnt < target) begin @(negedge clk); #1; end
      @(negedge clk); #1;
   endtask

   initial begin
      repeat (4) @(negedge clk);
      #1;
      chk("R1", "ce during reset", rom_ce_n, 4'hF);
      chk("R1", "oe during reset", rom_oe_n, 1);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("R1", "ce after reset", rom_ce_n, 4'hF);
      chk("R1", "oe after reset", rom_oe_n, 1);
      chk("R1", "valid after reset", rsp_valid, 0);
      chk("R1", "ready after reset", req_ready, 1);

      // single read: window lengths
      issue(16'h1234, 0);
      wait_rsp(1);
      chk("R4", "read data", last_rsp, rom_byte(16'h1234, 0));
      chk("R4", "ce low cycles", last_lo, ACC + 1);
      chk("R3", "oe low cycles", last_oe, ACC + 1 - OED);

      // same device back to back
      issue(16'h00FF, 1);
      issue(16'hFF00, 1);
      wait_rsp(3);
      chk("R8", "same-device gap", last_gap, 1);
      chk("R5", "second address data", last_rsp, rom_byte(16'hFF00, 1));

      // different device, request held until float gap ends
      issue(16'h0001, 2);
      issue(16'hABCD, 3);
      wait_rsp(5);
      chk("R7", "device-change gap", last_gap, FLT);
      chk("R7", "held read data", last_rsp, rom_byte(16'hABCD, 3));

      // request while busy is ignored
      issue(16'h5555, 0);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 16'hAAAA; req_bank = 2'd3;
      @(negedge clk);
      req_valid = 1'b0;
      wait_rsp(6);
      repeat (20) @(negedge clk);
      #1;
      chk("R6", "responses after busy request", rsp_cnt, 6);
      chk("R6", "data after busy request", last_rsp, rom_byte(16'h5555, 0));

      // sweep devices and address extremes
      for (int b = 0; b < 4; b++) begin
         for (int k = 0; k < 2; k++) begin
            logic [15:0] a;
            a = (k == 0) ? 16'h0000 : 16'hFFFF;
            issue(a, b);
            wait_rsp(rsp_cnt + 1);
            chk("R2", "sweep data", last_rsp, rom_byte(a, b));
         end
      end

      repeat (10) @(negedge clk);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule